// File: doc/BRIEF.md
# Compressor-Tree Unsigned Multiplier

This block multiplies two unsigned 8-bit operands and returns the full 16-bit product. The datapath has three parts. An array of two-input AND gates forms eight partial-product rows, with row i holding `op_a & {8{op_b[i]}}` shifted left by i. A three-level reduction tree brings the rows down to two. A single carry-propagate adder then sums those two rows.

The first level feeds five rows into a column of 5:2 compressors. Each compressor takes two carry-ins, one from the column one place below and one from two places below. The second level feeds the two rows from level one, plus rows 5 and 6, into a column of 4:2 compressors. These chain their carry-outs into the carry-in of the next column. Row 7 passes untouched to the third level, where full adders bring three rows down to two. Carries that would land above bit 15 are dropped, because the product always fits in 16 bits.

A parameter selects whether the product is registered. With the register, the result and its valid flag appear one clock after the operands are sampled. Without it, the result follows the operands combinationally.

Top module: `cmpt_mult`

## Requirements
- R1: For every pair of 8-bit unsigned operands, `prod` equals `op_a * op_b` as a 16-bit unsigned value.
- R2: Boundary operands give exact results: zero times any value is 0, one times x is x, and 255 times 255 is 65025 (0xFE01).
- R3: The 4:2 compressor has data inputs `x[3:0]` and carry-in `ci`. Its outputs satisfy `sum + 2*carry + 2*co` = number of ones among `x` and `ci`, and `co` does not depend on `ci`.
- R4: The 5:2 compressor has data inputs `x[4:0]` and carry-ins `ci_a` and `ci_b`. Its outputs satisfy `sum + 2*carry + 2*co_a + 4*co_b` = number of ones among all seven inputs, and neither `co_a` nor `co_b` depends on `ci_a` or `ci_b`.
- R5: With `REG_OUT=1`, a cycle with `in_valid` high at a rising edge yields `out_valid` high and `prod` equal to that cycle's product right after the next rising edge. Each such cycle yields exactly one result.
- R6: With `REG_OUT=1`, a cycle with `in_valid` low drives `out_valid` low after the next edge and leaves `prod` unchanged.
- R7: With `REG_OUT=1`, while `rst_n` is low, `prod` is 0 and `out_valid` is 0.
- R8: With `REG_OUT=0`, `prod` equals the product of the current operands in the same cycle, and `out_valid` equals `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands on `op_a`/`op_b` are to be multiplied |
| op_a | input | 8 | Unsigned multiplicand |
| op_b | input | 8 | Unsigned multiplier |
| prod | output | 16 | Unsigned product |
| out_valid | output | 1 | `prod` carries a fresh result |

## Verification
The bench builds the top twice, once with `REG_OUT=1` and once with `REG_OUT=0`. Both copies are driven with the same stream, so one run covers the one-cycle registered latency, the hold behaviour on idle cycles, and the same-cycle combinational path. The sweep covers all 65536 operand pairs through both copies. The two compressor cells are also instantiated on their own and driven over every input combination. This brings within reach the weight-conservation rule and the rule that carry-outs do not depend on carry-ins, which the tree only exercises indirectly.

// File: rtl/cmpt_pkg.sv
package cmpt_pkg;
  localparam int OPW = 8;
  localparam int PW  = 2 * OPW;

  typedef struct packed {
    logic c;
    logic s;
  } add_t;

  function automatic add_t fa(input logic x, input logic y, input logic z);
    add_t r;
    r.s = x ^ y ^ z;
    r.c = (x & y) | (z & (x ^ y));
    return r;
  endfunction

  function automatic add_t ha(input logic x, input logic y);
    add_t r;
    r.s = x ^ y;
    r.c = x & y;
    return r;
  endfunction

  // One partial-product row: gated multiplicand placed at its weight
  function automatic logic [PW-1:0] pp_row(input logic [OPW-1:0] mc,
                                           input logic bit_i, input int sh);
    logic [PW-1:0] t;
    t = {{(PW-OPW){1'b0}}, mc & {OPW{bit_i}}};
    return t << sh;
  endfunction
endpackage

// File: rtl/cmpt_c42.sv
module cmpt_c42
  import cmpt_pkg::*;
(
  input  logic [3:0] x,
  input  logic       ci,
  output logic       sum,
  output logic       carry,
  output logic       co
);
  add_t f1, f2;

  always_comb begin
    f1 = fa(x[0], x[1], x[2]);
    f2 = fa(f1.s, x[3], ci);
  end

  assign sum   = f2.s;
  assign carry = f2.c;
  assign co    = f1.c;

  always_comb begin
    if (!$isunknown({x, ci})) begin
      a_r3_weight: assert (int'(sum) + 2 * int'(carry) + 2 * int'(co) == $countones({x, ci}))
        else $error("c42 weight mismatch");
    end
  end
endmodule

// File: rtl/cmpt_c52.sv
module cmpt_c52
  import cmpt_pkg::*;
(
  input  logic [4:0] x,
  input  logic       ci_a,
  input  logic       ci_b,
  output logic       sum,
  output logic       carry,
  output logic       co_a,
  output logic       co_b
);
  add_t f1, f2, h, f3;

  always_comb begin
    f1 = fa(x[0], x[1], x[2]);
    f2 = fa(f1.s, x[3], x[4]);
    h  = ha(f1.c, f2.c);
    f3 = fa(f2.s, ci_a, ci_b);
  end

  assign sum   = f3.s;
  assign carry = f3.c;
  assign co_a  = h.s;
  assign co_b  = h.c;

  always_comb begin
    if (!$isunknown({x, ci_a, ci_b})) begin
      a_r4_weight: assert (int'(sum) + 2 * int'(carry) + 2 * int'(co_a) + 4 * int'(co_b)
                           == $countones({x, ci_a, ci_b}))
        else $error("c52 weight mismatch");
    end
  end
endmodule

// File: rtl/cmpt_rowstage.sv
module cmpt_rowstage
  import cmpt_pkg::*;
#(
  parameter int W   = PW,
  parameter int NIN = 3
) (
  input  logic [NIN-1:0][W-1:0] rows,
  output logic [W-1:0]          s_row,
  output logic [W-1:0]          c_row
);
  logic [W-1:0] cy;
  logic         cy_top_unused;

  if (NIN == 5) begin : g_c52
    logic [W-1:0] ta, tb;
    logic [2:0]   hi_unused;
    for (genvar j = 0; j < W; j++) begin : g_col
      logic cia, cib;
      if (j >= 1) begin : g_a
        assign cia = ta[j-1];
      end else begin : g_a0
        assign cia = 1'b0;
      end
      if (j >= 2) begin : g_b
        assign cib = tb[j-2];
      end else begin : g_b0
        assign cib = 1'b0;
      end
      cmpt_c52 u_c (
        .x    ({rows[4][j], rows[3][j], rows[2][j], rows[1][j], rows[0][j]}),
        .ci_a (cia),
        .ci_b (cib),
        .sum  (s_row[j]),
        .carry(cy[j]),
        .co_a (ta[j]),
        .co_b (tb[j])
      );
    end
    assign hi_unused = {ta[W-1], tb[W-1], tb[W-2]};
  end else if (NIN == 4) begin : g_c42
    logic [W-1:0] co;
    logic         hi_unused;
    for (genvar j = 0; j < W; j++) begin : g_col
      logic cin;
      if (j >= 1) begin : g_a
        assign cin = co[j-1];
      end else begin : g_a0
        assign cin = 1'b0;
      end
      cmpt_c42 u_c (
        .x    ({rows[3][j], rows[2][j], rows[1][j], rows[0][j]}),
        .ci   (cin),
        .sum  (s_row[j]),
        .carry(cy[j]),
        .co   (co[j])
      );
    end
    assign hi_unused = co[W-1];
  end else begin : g_c32
    always_comb begin
      add_t r;
      for (int j = 0; j < W; j++) begin
        r        = fa(rows[0][j], rows[1][j], rows[2][j]);
        s_row[j] = r.s;
        cy[j]    = r.c;
      end
    end
  end

  assign cy_top_unused = cy[W-1];
  assign c_row = {cy[W-2:0], 1'b0};

  // Each level keeps the row total modulo 2^W
  logic [W-1:0] in_tot;
  always_comb begin
    in_tot = '0;
    for (int k = 0; k < NIN; k++) in_tot = in_tot + rows[k];
  end

  always_comb begin
    if (!$isunknown(rows)) begin
      a_r1_level_total: assert (W'(s_row + c_row) == in_tot)
        else $error("reduction level changed the row total");
    end
  end
endmodule

// File: rtl/cmpt_mult.sv
module cmpt_mult
  import cmpt_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [OPW-1:0] op_a,
  input  logic [OPW-1:0] op_b,
  output logic [PW-1:0]  prod,
  output logic           out_valid
);
  logic [OPW-1:0][PW-1:0] pp;
  logic [PW-1:0] s1, c1, s2, c2, final_s, final_c, prod_c;

  always_comb begin
    for (int i = 0; i < OPW; i++) pp[i] = pp_row(op_a, op_b[i], i);
  end

  // Level 1: rows 0..4 into 5:2 compressors
  cmpt_rowstage #(.W(PW), .NIN(5)) u_lvl1 (
    .rows (pp[4:0]),
    .s_row(s1),
    .c_row(c1)
  );

  // Level 2: level-1 rows plus rows 5 and 6 into 4:2 compressors
  cmpt_rowstage #(.W(PW), .NIN(4)) u_lvl2 (
    .rows ({pp[6], pp[5], c1, s1}),
    .s_row(s2),
    .c_row(c2)
  );

  // Level 3: row 7, held back until now, into full adders
  cmpt_rowstage #(.W(PW), .NIN(3)) u_lvl3 (
    .rows ({pp[7], c2, s2}),
    .s_row(final_s),
    .c_row(final_c)
  );

  assign prod_c = final_s + final_c;

  always_comb begin
    if (!$isunknown({op_a, op_b})) begin
      a_r1_tree_exact: assert (prod_c == PW'(op_a) * PW'(op_b))
        else $error("tree product mismatch");
    end
  end

  if (REG_OUT) begin : g_reg
    logic [PW-1:0] prod_q;
    logic          vld_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prod_q <= '0;
        vld_q  <= 1'b0;
      end else begin
        vld_q <= in_valid;
        if (in_valid) prod_q <= prod_c;
      end
    end
    assign prod      = prod_q;
    assign out_valid = vld_q;

    a_r5_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    a_r5_value_next: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> prod == PW'($past(op_a)) * PW'($past(op_b)));
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && $stable(prod));
    always_comb begin
      if (!rst_n) begin
        a_r7_reset_clear: assert (prod == '0 && !out_valid)
          else $error("outputs not cleared in reset");
      end
    end
  end else begin : g_comb
    logic [1:0] clk_unused;
    assign clk_unused = {clk, rst_n};
    assign prod       = prod_c;
    assign out_valid  = in_valid;
  end
endmodule

// File: tb/cmpt_mult_bench.sv
module cmpt_mult_bench;
  import cmpt_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [OPW-1:0] a_i = '0, b_i = '0;
  logic [PW-1:0] prod_r, prod_k;
  logic vld_r, vld_k;

  always #10 clk = ~clk;  // 50 MHz

  cmpt_mult #(.REG_OUT(1'b1)) u_cmpt_mult (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(a_i), .op_b(b_i),
    .prod(prod_r), .out_valid(vld_r));

  cmpt_mult #(.REG_OUT(1'b0)) u_cmpt_mult_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(a_i), .op_b(b_i),
    .prod(prod_k), .out_valid(vld_k));

  logic [3:0] c4x = '0;
  logic c4ci = 1'b0;
  logic c4s, c4c, c4co;
  cmpt_c42 u_c42 (.x(c4x), .ci(c4ci), .sum(c4s), .carry(c4c), .co(c4co));

  logic [4:0] c5x = '0;
  logic c5a = 1'b0, c5b = 1'b0;
  logic c5s, c5c, c5oa, c5ob;
  cmpt_c52 u_c52 (.x(c5x), .ci_a(c5a), .ci_b(c5b), .sum(c5s), .carry(c5c),
                  .co_a(c5oa), .co_b(c5ob));

  int n_run = 0, n_fail = 0;
  logic [PW-1:0] expq[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [OPW-1:0] x, input logic [OPW-1:0] y);
    logic [PW-1:0] e;
    @(negedge clk);
    a_i = x;
    b_i = y;
    in_valid = 1'b1;
    e = PW'(x) * PW'(y);
    expq.push_back(e);
    #1;
    check(prod_k == e, "R8", "same-cycle product", prod_k, e);
    check(vld_k == 1'b1, "R8", "valid follows input", PW'(vld_k), 1);
  endtask

  // Monitor: scoreboard for the registered copy (R1, R5)
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && vld_r) begin
        if (expq.size() == 0) begin
          check(1'b0, "R5", "result without sampled input", prod_r, 0);
        end else begin
          logic [PW-1:0] e;
          e = expq.pop_front();
          check(prod_r == e, "R1", "registered product", prod_r, e);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired (hung=1, done=0)", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R7: reset state
    repeat (3) @(negedge clk);
    check(prod_r == '0, "R7", "product in reset", prod_r, 0);
    check(vld_r == 1'b0, "R7", "valid in reset", PW'(vld_r), 0);

    // R3: 4:2 cell, all inputs
    for (int v = 0; v < 32; v++) begin
      c4x = v[3:0];
      c4ci = v[4];
      #1;
      check(PW'(c4s) + 2 * PW'(c4c) + 2 * PW'(c4co) == PW'($countones(v[4:0])),
            "R3", "c42 weighted outputs", PW'(c4s) + 2 * PW'(c4c) + 2 * PW'(c4co),
            PW'($countones(v[4:0])));
    end
    for (int v = 0; v < 16; v++) begin
      logic co0;
      c4x = v[3:0];
      c4ci = 1'b0;
      #1;
      co0 = c4co;
      c4ci = 1'b1;
      #1;
      check(c4co == co0, "R3", "c42 carry-out vs carry-in", PW'(c4co), PW'(co0));
    end

    // R4: 5:2 cell, all inputs
    for (int v = 0; v < 128; v++) begin
      c5x = v[4:0];
      c5a = v[5];
      c5b = v[6];
      #1;
      check(PW'(c5s) + 2 * PW'(c5c) + 2 * PW'(c5oa) + 4 * PW'(c5ob) == PW'($countones(v[6:0])),
            "R4", "c52 weighted outputs",
            PW'(c5s) + 2 * PW'(c5c) + 2 * PW'(c5oa) + 4 * PW'(c5ob), PW'($countones(v[6:0])));
    end
    for (int v = 0; v < 32; v++) begin
      logic [1:0] ref_co;
      c5x = v[4:0];
      {c5a, c5b} = 2'b00;
      #1;
      ref_co = {c5oa, c5ob};
      for (int k = 1; k < 4; k++) begin
        {c5a, c5b} = k[1:0];
        #1;
        check({c5oa, c5ob} == ref_co, "R4", "c52 carry-outs vs carry-ins",
              PW'({c5oa, c5ob}), PW'(ref_co));
      end
    end

    @(negedge clk);
    rst_n = 1'b1;

    // R2: boundary operands
    drive(8'd0, 8'd200);
    check(prod_k == 16'd0, "R2", "zero times 200", prod_k, 0);
    drive(8'd1, 8'd173);
    check(prod_k == 16'd173, "R2", "one times 173", prod_k, 173);
    drive(8'd173, 8'd1);
    check(prod_k == 16'd173, "R2", "173 times one", prod_k, 173);
    drive(8'd255, 8'd255);
    check(prod_k == 16'hFE01, "R2", "255 times 255", prod_k, 16'hFE01);
    drive(8'd128, 8'd2);

    // R6: idle cycle keeps product, drops valid
    @(negedge clk);
    in_valid = 1'b0;
    a_i = 8'd77;
    b_i = 8'd99;
    #1;
    check(vld_k == 1'b0, "R8", "valid low with idle input", PW'(vld_k), 0);
    @(posedge clk);
    #3;
    check(vld_r == 1'b0, "R6", "valid after idle cycle", PW'(vld_r), 0);
    check(prod_r == 16'd256, "R6", "product held over idle cycle", prod_r, 256);

    // R5: one-cycle latency
    drive(8'd3, 8'd5);
    check(prod_r == 16'd256, "R5", "old product before edge", prod_r, 256);
    check(vld_r == 1'b0, "R5", "valid before edge", PW'(vld_r), 0);
    @(posedge clk);
    #3;
    check(prod_r == 16'd15, "R5", "product after edge", prod_r, 15);
    check(vld_r == 1'b1, "R5", "valid after edge", PW'(vld_r), 1);

    // R1: full sweep, back to back
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        drive(x[7:0], y[7:0]);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R5", "every sampled input produced a result",
          PW'(expq.size()), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule